// File: doc/BRIEF.md
# Macro Processor Arithmetic and Bitfield Unit

This unit is the execute stage of a small macro processor. It is purely combinational. The unit takes three inputs: the 32-bit instruction word, two operand values already read from the register file, and the carry flag stored by the surrounding sequencer. From these it computes one result word.

It also reports a new carry value and a carry write-enable, which the sequencer uses to update its flag register. For the register-read operation, the unit drives an address onto the engine-register read port. The word returned on that port becomes the result in the same cycle.

Bits 2:0 of the instruction choose the operation class:
- 0 selects register arithmetic or logic.
- 1 selects add-immediate.
- 2 selects bitfield insert.
- 3 selects extract with a fixed left shift.
- 4 selects extract with a left shift taken from A.
- 5 selects the engine-register read.

The signed immediate sits in bits 31:14. The three bitfield forms share one set of fields:
- bits 21:17 give the source position.
- bits 26:22 give the field width.
- bits 31:27 give the destination position.

Top module: `macro_alu`

## Requirements
- R1: With operation class 1, result equals A plus the sign-extended 18-bit immediate from bits 31:14, modulo 2^32, and carry_we is 0.
- R2: With class 0 and register op 0 (bits 21:17), result is (A+B) mod 2^32, carry_we is 1, and carry_out is 1 exactly when the unsigned sum is at least 2^32.
- R3: Register op 1 adds carry_in as well: result is (A+B+carry_in) mod 2^32, and carry_out is 1 when that unsigned sum is at least 2^32. carry_we is 1.
- R4: Register op 2 gives (A-B) mod 2^32 with carry_we 1, and carry_out is 1 exactly when A >= B (unsigned).
- R5: Register op 3 gives (A-B-(1-carry_in)) mod 2^32 with carry_we 1, and carry_out is 1 exactly when A >= B+(1-carry_in) (unsigned).
- R6: Register ops 8 to 12 give, in that order: A XOR B, A OR B, A AND B, A AND NOT B, and NOT(A AND B). For these ops carry_we is 0 and carry_out equals carry_in.
- R7: Class 2 (insert) takes the field of B that starts at the source position, with the field width set by bits 26:22. It writes that field into A at the destination position. All other bits of A are kept.
- R8: Class 3 shifts B right by A[4:0], keeps the low width bits, then shifts them left by the destination position. The upper bits of A have no effect.
- R9: Class 4 shifts B right by the source position, keeps the low width bits, then shifts them left by A[4:0]. The upper bits of A have no effect.
- R10: With class 5, rd_addr carries the low 12 bits of A plus the immediate, result equals rd_data, and carry_we is 0.
- R11: Undefined codes (class 6 or 7, register ops 4-7 and 13-31) give result 0 with carry_we 0 and carry_out equal to carry_in.
- R12: A field width of 0 yields an empty field. Extracts then give 0, and insert returns A unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word |
| opnd_a | input | 32 | Operand A |
| opnd_b | input | 32 | Operand B |
| carry_in | input | 1 | Stored carry flag |
| rd_data | input | 32 | Data returned by the engine-register read port |
| result | output | 32 | Computed result |
| carry_out | output | 1 | Next carry value (equals carry_in when not written) |
| carry_we | output | 1 | Carry write-enable |
| rd_addr | output | 12 | Engine-register read address |

## Verification
The arithmetic ops are driven with operand pairs on both sides of each carry boundary:
- all-ones plus one, and small sums, for addition;
- A greater than, equal to, and less than B, for subtraction;
- each of these with carry_in both 0 and 1.

These pairs separate a correct carry from an inverted borrow convention and from a missing carry term. The logic ops are run with carry_in set, which shows that the flag is left alone. The bitfield forms are run with A values whose bits above bit 4 are set, and with widths of 0, 4, 8, 12 and 31. This shows whether a shift takes only the low bits of A, and whether the source and destination positions are swapped. Negative immediates that wrap the read address, together with every undefined code, check the sign extension and the zero default.

// File: rtl/macro_alu_pkg.sv
package macro_alu_pkg;

    localparam int INSTR_W = 32;
    localparam int FLD_W   = 5;
    localparam int IMM_LSB = 14;
    localparam int IMM_W   = INSTR_W - IMM_LSB;

    // field positions inside the instruction word
    localparam int SEL_LSB  = 0;
    localparam int SUB_LSB  = 17;
    localparam int SIZE_LSB = 22;
    localparam int DST_LSB  = 27;

    typedef enum logic [2:0] {
        SEL_REGOP   = 3'd0,
        SEL_ADDIMM  = 3'd1,
        SEL_BFINS   = 3'd2,
        SEL_EXT_IMM = 3'd3,
        SEL_EXT_REG = 3'd4,
        SEL_RDREG   = 3'd5
    } alu_sel_e;

    typedef enum logic [FLD_W-1:0] {
        RO_ADD  = 5'd0,
        RO_ADC  = 5'd1,
        RO_SUB  = 5'd2,
        RO_SBB  = 5'd3,
        RO_XOR  = 5'd8,
        RO_OR   = 5'd9,
        RO_AND  = 5'd10,
        RO_ANDN = 5'd11,
        RO_NAND = 5'd12
    } reg_op_e;

endpackage

// File: rtl/macro_alu_regop.sv
module macro_alu_regop
    import macro_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [FLD_W-1:0]  sub_op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              cout,
    output logic              cwe
);

    localparam int EXT_W = DATA_W + 1;

    logic [EXT_W-1:0] sum_x;
    logic [EXT_W-1:0] dif_x;
    logic             add_in;
    logic             brw_in;

    always_comb begin
        // carry term for add-with-carry, borrow term for subtract-with-borrow
        add_in = (sub_op == RO_ADC) ? cin  : 1'b0;
        brw_in = (sub_op == RO_SBB) ? ~cin : 1'b0;
        sum_x  = {1'b0, a} + {1'b0, b} + EXT_W'(add_in);
        dif_x  = {1'b0, a} - {1'b0, b} - EXT_W'(brw_in);
    end

    always_comb begin
        res  = '0;
        cout = cin;
        cwe  = 1'b0;
        case (reg_op_e'(sub_op))
            RO_ADD, RO_ADC: begin
                res  = sum_x[DATA_W-1:0];
                cout = sum_x[DATA_W];
                cwe  = 1'b1;
            end
            RO_SUB, RO_SBB: begin
                res  = dif_x[DATA_W-1:0];
                cout = ~dif_x[DATA_W];
                cwe  = 1'b1;
            end
            RO_XOR:  res = a ^ b;
            RO_OR:   res = a | b;
            RO_AND:  res = a & b;
            RO_ANDN: res = a & ~b;
            RO_NAND: res = ~(a & b);
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/macro_alu_bitfield.sv
module macro_alu_bitfield
    import macro_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_sel_e          form,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [FLD_W-1:0]  src_pos,
    input  logic [FLD_W-1:0]  width,
    input  logic [FLD_W-1:0]  dst_pos,
    output logic [DATA_W-1:0] res
);

    localparam int SH_W = $clog2(DATA_W);

    logic [DATA_W-1:0] mask;
    logic [SH_W-1:0]   a_sh;
    logic [DATA_W-1:0] fld_src;
    logic [DATA_W-1:0] fld_a;

    always_comb begin
        mask    = (DATA_W'(1) << width) - DATA_W'(1);
        a_sh    = a[SH_W-1:0];
        fld_src = (b >> src_pos) & mask;
        fld_a   = (b >> a_sh) & mask;
    end

    always_comb begin
        case (form)
            SEL_BFINS:   res = (a & ~(mask << dst_pos)) | (fld_src << dst_pos);
            SEL_EXT_IMM: res = fld_a << dst_pos;
            SEL_EXT_REG: res = fld_src << a_sh;
            default:     res = '0;
        endcase
    end

endmodule

// File: rtl/macro_alu.sv
module macro_alu
    import macro_alu_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int RD_ADDR_W = 12
) (
    input  logic [INSTR_W-1:0]   instr,
    input  logic [DATA_W-1:0]    opnd_a,
    input  logic [DATA_W-1:0]    opnd_b,
    input  logic                 carry_in,
    input  logic [DATA_W-1:0]    rd_data,
    output logic [DATA_W-1:0]    result,
    output logic                 carry_out,
    output logic                 carry_we,
    output logic [RD_ADDR_W-1:0] rd_addr
);

    alu_sel_e          sel;
    logic [FLD_W-1:0]  f_sub;
    logic [FLD_W-1:0]  f_size;
    logic [FLD_W-1:0]  f_dst;
    logic [DATA_W-1:0] imm_sx;
    logic [DATA_W-1:0] a_plus_imm;

    logic [DATA_W-1:0] reg_res;
    logic              reg_cout;
    logic              reg_cwe;
    logic [DATA_W-1:0] bf_res;
    logic              unused_bits;

    always_comb begin
        sel        = alu_sel_e'(instr[SEL_LSB +: 3]);
        f_sub      = instr[SUB_LSB  +: FLD_W];
        f_size     = instr[SIZE_LSB +: FLD_W];
        f_dst      = instr[DST_LSB  +: FLD_W];
        imm_sx     = DATA_W'($signed(instr[INSTR_W-1:IMM_LSB]));
        a_plus_imm = opnd_a + imm_sx;
    end

    assign unused_bits = ^{instr[IMM_LSB-1:3], a_plus_imm[DATA_W-1:RD_ADDR_W]};

    macro_alu_regop #(.DATA_W(DATA_W)) u_regop (
        .sub_op (f_sub),
        .a      (opnd_a),
        .b      (opnd_b),
        .cin    (carry_in),
        .res    (reg_res),
        .cout   (reg_cout),
        .cwe    (reg_cwe)
    );

    macro_alu_bitfield #(.DATA_W(DATA_W)) u_bitfield (
        .form    (sel),
        .a       (opnd_a),
        .b       (opnd_b),
        .src_pos (f_sub),
        .width   (f_size),
        .dst_pos (f_dst),
        .res     (bf_res)
    );

    assign rd_addr = a_plus_imm[RD_ADDR_W-1:0];

    always_comb begin
        result   = '0;
        carry_we = 1'b0;
        case (sel)
            SEL_REGOP: begin
                result   = reg_res;
                carry_we = reg_cwe;
            end
            SEL_ADDIMM:                        result = a_plus_imm;
            SEL_BFINS, SEL_EXT_IMM, SEL_EXT_REG: result = bf_res;
            SEL_RDREG:                         result = rd_data;
            default:                           result = '0;
        endcase
        carry_out = carry_we ? reg_cout : carry_in;
    end

endmodule

// File: rtl/macro_alu_chk.sv
module macro_alu_chk
    import macro_alu_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int RD_ADDR_W = 12
) (
    input logic [INSTR_W-1:0]   instr,
    input logic [DATA_W-1:0]    opnd_a,
    input logic [DATA_W-1:0]    opnd_b,
    input logic                 carry_in,
    input logic [DATA_W-1:0]    rd_data,
    input logic [DATA_W-1:0]    result,
    input logic                 carry_out,
    input logic                 carry_we,
    input logic [RD_ADDR_W-1:0] rd_addr
);

    logic [2:0]       c_sel;
    logic [FLD_W-1:0] c_sub;
    logic [DATA_W:0]  c_sum;
    logic             unused_chk;

    assign c_sel      = instr[2:0];
    assign c_sub      = instr[21:17];
    assign c_sum      = {1'b0, opnd_a} + {1'b0, opnd_b};
    assign unused_chk = ^rd_addr;

    always_comb begin
        // R2
        add_flag_chk: assert (!(c_sel == 3'd0 && c_sub == 5'd0) ||
                              ({carry_out, result} == c_sum && carry_we));
        // R6
        logic_carry_hold_chk: assert (!(c_sel == 3'd0 && c_sub >= 5'd8 && c_sub <= 5'd12) ||
                                      (!carry_we && carry_out == carry_in));
        // R10
        read_pass_chk: assert (c_sel != 3'd5 || (result == rd_data && !carry_we));
        // R11
        undef_zero_chk: assert (c_sel < 3'd6 || (result == '0 && !carry_we));
        // R1
        flag_write_scope_chk: assert (!carry_we || (c_sel == 3'd0 && c_sub < 5'd4));
    end

endmodule

bind macro_alu macro_alu_chk #(.DATA_W(DATA_W), .RD_ADDR_W(RD_ADDR_W)) u_chk (
    .instr     (instr),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .carry_in  (carry_in),
    .rd_data   (rd_data),
    .result    (result),
    .carry_out (carry_out),
    .carry_we  (carry_we),
    .rd_addr   (rd_addr)
);

// File: tb/test_macro_alu.sv
module test_macro_alu;

    logic        clk = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        carry_in = 1'b0;
    logic [31:0] rd_data = 32'hCAFE_F00D;
    logic [31:0] result;
    logic        carry_out;
    logic        carry_we;
    logic [11:0] rd_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [31:0] res;
        logic        cwe;
        logic        cout;
        bit          chk_addr;
        logic [11:0] addr;
        string       tag;
    } exp_t;

    exp_t sb_q[$];

    always #10 clk = ~clk;

    macro_alu i_macro_alu (
        .instr     (instr),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .carry_in  (carry_in),
        .rd_data   (rd_data),
        .result    (result),
        .carry_out (carry_out),
        .carry_we  (carry_we),
        .rd_addr   (rd_addr)
    );

    function automatic logic [31:0] w_reg(input int sub);
        return {10'd0, sub[4:0], 17'd0};
    endfunction

    function automatic logic [31:0] w_bf(input int cls, input int src, input int sz, input int dst);
        return {dst[4:0], sz[4:0], src[4:0], 14'd0, cls[2:0]};
    endfunction

    function automatic logic [31:0] w_imm(input int cls, input int imm);
        logic [31:0] iv = imm;
        return {iv[17:0], 11'd0, cls[2:0]};
    endfunction

    function automatic logic [31:0] lowmask(input int n);
        logic [31:0] m = '0;
        for (int k = 0; k < n; k++) m[k] = 1'b1;
        return m;
    endfunction

    task automatic apply(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                         input logic ci, input logic [31:0] e_res, input logic e_cwe,
                         input logic e_cout, input bit ca, input logic [11:0] e_addr,
                         input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        instr = ins; opnd_a = a; opnd_b = b; carry_in = ci;
        e.res = e_res; e.cwe = e_cwe; e.cout = e_cout;
        e.chk_addr = ca; e.addr = e_addr; e.tag = tag;
        sb_q.push_back(e);
    endtask

    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_checks++;
            if (result !== e.res || carry_we !== e.cwe || carry_out !== e.cout ||
                (e.chk_addr && rd_addr !== e.addr)) begin
                n_fail++;
                $display("FAIL %s: got res=%h cwe=%b cout=%b addr=%h, exp res=%h cwe=%b cout=%b addr=%h",
                         e.tag, result, carry_we, carry_out, rd_addr,
                         e.res, e.cwe, e.cout, e.addr);
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout, exp completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // idle inputs: register add of zeros
        apply(32'd0, 32'd0, 32'd0, 1'b0, 32'd0, 1'b1, 1'b0, 0, 12'd0, "R2 idle");
        // R1 add immediate, positive and negative
        apply(w_imm(1, -3), 32'd10, 32'd0, 1'b1, 32'd7, 1'b0, 1'b1, 0, 12'd0, "R1 addi neg");
        apply(w_imm(1, 131071), 32'd1, 32'd0, 1'b0, 32'h0002_0000, 1'b0, 1'b0, 0, 12'd0, "R1 addi max");
        // R2 add
        apply(w_reg(0), 32'hFFFF_FFFF, 32'd1, 1'b0, 32'd0, 1'b1, 1'b1, 0, 12'd0, "R2 add wrap");
        apply(w_reg(0), 32'd5, 32'd7, 1'b1, 32'd12, 1'b1, 1'b0, 0, 12'd0, "R2 add small");
        // R3 add with carry
        apply(w_reg(1), 32'hFFFF_FFFF, 32'd0, 1'b1, 32'd0, 1'b1, 1'b1, 0, 12'd0, "R3 adc wrap");
        apply(w_reg(1), 32'd1, 32'd2, 1'b1, 32'd4, 1'b1, 1'b0, 0, 12'd0, "R3 adc cin1");
        apply(w_reg(1), 32'hFFFF_FFFF, 32'd0, 1'b0, 32'hFFFF_FFFF, 1'b1, 1'b0, 0, 12'd0, "R3 adc cin0");
        // R4 subtract
        apply(w_reg(2), 32'd5, 32'd3, 1'b0, 32'd2, 1'b1, 1'b1, 0, 12'd0, "R4 sub gt");
        apply(w_reg(2), 32'd3, 32'd5, 1'b1, 32'hFFFF_FFFE, 1'b1, 1'b0, 0, 12'd0, "R4 sub lt");
        apply(w_reg(2), 32'd9, 32'd9, 1'b0, 32'd0, 1'b1, 1'b1, 0, 12'd0, "R4 sub eq");
        // R5 subtract with borrow
        apply(w_reg(3), 32'd5, 32'd5, 1'b0, 32'hFFFF_FFFF, 1'b1, 1'b0, 0, 12'd0, "R5 sbb borrow");
        apply(w_reg(3), 32'd5, 32'd5, 1'b1, 32'd0, 1'b1, 1'b1, 0, 12'd0, "R5 sbb noborrow");
        apply(w_reg(3), 32'd6, 32'd5, 1'b0, 32'd0, 1'b1, 1'b1, 0, 12'd0, "R5 sbb exact");
        // R6 logic ops, flag held
        apply(w_reg(8),  32'hF0F0_1234, 32'h0FF0_FFFF, 1'b1, 32'hFF00_EDCB, 1'b0, 1'b1, 0, 12'd0, "R6 xor");
        apply(w_reg(9),  32'hF0F0_1234, 32'h0FF0_0000, 1'b0, 32'hFFF0_1234, 1'b0, 1'b0, 0, 12'd0, "R6 or");
        apply(w_reg(10), 32'hF0F0_1234, 32'h0FF0_FF00, 1'b1, 32'h00F0_1200, 1'b0, 1'b1, 0, 12'd0, "R6 and");
        apply(w_reg(11), 32'hF0F0_1234, 32'h0FF0_FF00, 1'b1, 32'hF000_0034, 1'b0, 1'b1, 0, 12'd0, "R6 andn");
        apply(w_reg(12), 32'hF0F0_1234, 32'h0FF0_FF00, 1'b0, 32'hFF0F_EDFF, 1'b0, 1'b0, 0, 12'd0, "R6 nand");
        // R7 insert
        apply(w_bf(2, 4, 4, 8), 32'hFFFF_FFFF, 32'h0000_00AB, 1'b0, 32'hFFFF_FAFF, 1'b0, 1'b0, 0, 12'd0, "R7 insert");
        apply(w_bf(2, 0, 31, 1), 32'h0000_0001, 32'hFFFF_FFFF, 1'b0,
              (32'h1 & ~(lowmask(31) << 1)) | (lowmask(31) << 1), 1'b0, 1'b0, 0, 12'd0, "R7 insert wide");
        // R8 extract, shift from A
        apply(w_bf(3, 0, 8, 4), 32'd8, 32'h1234_5678, 1'b0, 32'h0000_0560, 1'b0, 1'b0, 0, 12'd0, "R8 ext imm");
        apply(w_bf(3, 0, 8, 4), 32'hFFFF_FFE8, 32'h1234_5678, 1'b1, 32'h0000_0560, 1'b0, 1'b1, 0, 12'd0, "R8 ext imm A high");
        // R9 extract, left shift by A
        apply(w_bf(4, 16, 12, 0), 32'h10, 32'h1234_5678, 1'b0, 32'h0234_0000, 1'b0, 1'b0, 0, 12'd0, "R9 ext reg");
        apply(w_bf(4, 16, 12, 9), 32'hFFFF_FFE4, 32'h1234_5678, 1'b0, 32'h0000_2340, 1'b0, 1'b0, 0, 12'd0, "R9 ext reg A high");
        // R12 zero width
        apply(w_bf(2, 3, 0, 5), 32'h1357_9BDF, 32'hFFFF_FFFF, 1'b0, 32'h1357_9BDF, 1'b0, 1'b0, 0, 12'd0, "R12 insert w0");
        apply(w_bf(3, 3, 0, 5), 32'd0, 32'hFFFF_FFFF, 1'b0, 32'd0, 1'b0, 1'b0, 0, 12'd0, "R12 ext imm w0");
        apply(w_bf(4, 3, 0, 5), 32'd0, 32'hFFFF_FFFF, 1'b0, 32'd0, 1'b0, 1'b0, 0, 12'd0, "R12 ext reg w0");
        // R10 register read
        apply(w_imm(5, 32), 32'h100, 32'd0, 1'b1, 32'hCAFE_F00D, 1'b0, 1'b1, 1, 12'h120, "R10 read");
        apply(w_imm(5, -6), 32'd5, 32'd0, 1'b0, 32'hCAFE_F00D, 1'b0, 1'b0, 1, 12'hFFF, "R10 read wrap");
        // R11 undefined codes
        apply(32'hFFFF_FFF6, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 32'd0, 1'b0, 1'b1, 0, 12'd0, "R11 class6");
        apply(32'h0000_0007, 32'd3, 32'd4, 1'b0, 32'd0, 1'b0, 1'b0, 0, 12'd0, "R11 class7");
        apply(w_reg(4), 32'd3, 32'd4, 1'b1, 32'd0, 1'b0, 1'b1, 0, 12'd0, "R11 regop4");
        apply(w_reg(13), 32'd3, 32'd4, 1'b0, 32'd0, 1'b0, 1'b0, 0, 12'd0, "R11 regop13");
        apply(w_reg(31), 32'd3, 32'd4, 1'b1, 32'd0, 1'b0, 1'b1, 0, 12'd0, "R11 regop31");
        @(posedge clk);
        @(posedge clk);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule